// File: doc/BRIEF.md
# Software Interrupt Broadcast Dispatcher

This block sits behind the software-interrupt generation register of an interrupt distributor serving up to eight CPUs. When a CPU writes that register, the block splits the 32-bit word into an interrupt number, a 2-bit filter mode and an 8-bit CPU list. It works out which CPUs receive the interrupt, then raises one-cycle update pulses. Each pulse tells the pending store to set the addressed interrupt's pending latch for a receiving CPU, and to OR the writer's bit into that interrupt's source mask.

The filter mode chooses the receivers. The block can use the explicit list, every online CPU except the writer, or the writer alone. The fourth code is reserved and discards the write. CPUs at or beyond the online count are never updated. Reads of the register return zero. Priority arbitration and delivery to the CPUs belong to downstream logic.

Top module: `swint_fanout`

## Requirements
- R1: The interrupt number is write-data bits [3:0]. A write produces pending pulses only at that interrupt number, for any CPU.
- R2: With filter mode 0 (bits [25:24] = 0), the receivers are the CPUs whose bit is set in the list field, bits [23:16] (bit 16 is CPU 0).
- R3: With filter mode 1, the receivers are all online CPUs except the writing CPU. The list field is ignored.
- R4: With filter mode 2, the only receiver is the writing CPU. The list field is ignored.
- R5: With filter mode 3, the write has no effect and no pending or source pulse is raised.
- R6: For every receiver, the source pulse is raised at the writing CPU's index within that interrupt's source group, and at no other index. A source pulse is present exactly where a pending pulse is.
- R7: A CPU whose index is at or above the online count never receives a pulse in any mode. An online count above 8 acts as 8.
- R8: All pulses from one write appear together, one cycle after the clock edge that samples the write strobe. They last one cycle. No pulse appears in a cycle that follows a cycle without a strobe.
- R9: The read data of the generation register is always zero.
- R10: While reset is asserted, and in the first cycle after it, all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the generation register |
| wr_data | input | 32 | Written word |
| req_cpu | input | 3 | Index of the writing CPU |
| online_cnt | input | 4 | Number of online CPUs |
| rd_data | output | 32 | Read value of the generation register |
| pend_set | output | 128 | Pending-set pulses, bit cpu*16 + id |
| src_set | output | 1024 | Source-set pulses, bit (cpu*16 + id)*8 + source |

## Verification
Two events can fall in the same cycle. One is the registered update from one write. The other is the decode of the next write, when the strobe is held high over successive cycles. The bench runs a train of back-to-back writes that change mode, writer, list and interrupt number every cycle. It requires each output cycle to carry exactly the pulses of the write sampled one edge earlier, with nothing carried over from older or newer writes. The pending pulse and its source pulse also arrive in the same cycle, and the bench checks both vectors on every update.

// File: rtl/swint_pkg.sv
package swint_pkg;

  // Field positions of the generation register word
  localparam int ID_LSB   = 0;
  localparam int ID_FLD_W = 4;
  localparam int LIST_LSB = 16;
  localparam int LIST_W   = 8;
  localparam int MODE_LSB = 24;
  localparam int MODE_W   = 2;
  localparam int MAX_CPUS = 8;

  typedef enum logic [MODE_W-1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_mode_e;

  typedef struct packed {
    flt_mode_e             mode;
    logic [LIST_W-1:0]     list;
    logic [ID_FLD_W-1:0]   id;
  } swint_req_t;

  // Bit b set when CPU b is below the online count (count saturates at MAX_CPUS)
  function automatic logic [LIST_W-1:0] live_cpus(input logic [3:0] cnt);
    logic [LIST_W-1:0] m;
    for (int b = 0; b < LIST_W; b++) begin
      m[b] = (int'(cnt) > b);
    end
    return m;
  endfunction

  // Receiver set for one request before width trimming
  function automatic logic [LIST_W-1:0] pick_targets(
    input flt_mode_e         mode,
    input logic [LIST_W-1:0] list,
    input logic [LIST_W-1:0] self_oh,
    input logic [LIST_W-1:0] live
  );
    logic [LIST_W-1:0] t;
    unique case (mode)
      FLT_LIST:   t = list & live;
      FLT_OTHERS: t = live & ~self_oh;
      FLT_SELF:   t = self_oh & live;
      default:    t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/swint_field_decode.sv
module swint_field_decode
  import swint_pkg::*;
(
  input  logic [31:0] wr_data,
  output swint_req_t  req
);

  logic unused_fields;

  assign req.id   = wr_data[ID_LSB +: ID_FLD_W];
  assign req.list = wr_data[LIST_LSB +: LIST_W];
  assign req.mode = flt_mode_e'(wr_data[MODE_LSB +: MODE_W]);

  assign unused_fields = ^{wr_data[31:MODE_LSB+MODE_W], wr_data[LIST_LSB-1:ID_LSB+ID_FLD_W]};

endmodule

// File: rtl/swint_target_sel.sv
module swint_target_sel
  import swint_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W = $clog2(NUM_CPUS + 1)
) (
  input  swint_req_t          req,
  input  logic [CPU_W-1:0]    req_cpu,
  input  logic [CNT_W-1:0]    online_cnt,
  output logic [NUM_CPUS-1:0] tgt_mask,
  output logic                rsvd
);

  logic [LIST_W-1:0] self_oh;
  logic [LIST_W-1:0] live;
  logic [LIST_W-1:0] picked;

  assign self_oh  = LIST_W'(1) << req_cpu;
  assign live     = live_cpus(4'(online_cnt));
  assign picked   = pick_targets(req.mode, req.list, self_oh, live);
  assign tgt_mask = picked[NUM_CPUS-1:0];
  assign rsvd     = (req.mode == FLT_RSVD);

endmodule

// File: rtl/swint_pulse_bank.sv
module swint_pulse_bank #(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IDS  = 16,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int PEND_W = NUM_CPUS * NUM_IDS,
  localparam int SRC_W  = PEND_W * NUM_CPUS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [NUM_CPUS-1:0] tgt_mask,
  input  logic [ID_W-1:0]     id,
  input  logic [CPU_W-1:0]    req_cpu,
  output logic [PEND_W-1:0]   pend_set,
  output logic [SRC_W-1:0]    src_set
);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      localparam int K = c * NUM_IDS + i;
      logic hit;
      logic pend_r;

      assign hit = fire & tgt_mask[c] & (id == ID_W'(i));

      always_ff @(posedge clk) begin
        if (!rst_n) pend_r <= 1'b0;
        else        pend_r <= hit;
      end
      assign pend_set[K] = pend_r;

      for (genvar s = 0; s < NUM_CPUS; s++) begin : g_src
        logic src_r;
        always_ff @(posedge clk) begin
          if (!rst_n) src_r <= 1'b0;
          else        src_r <= hit & (req_cpu == CPU_W'(s));
        end
        assign src_set[K*NUM_CPUS + s] = src_r;
      end
    end
  end

endmodule

// File: rtl/swint_fanout.sv
module swint_fanout
  import swint_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IDS  = 16,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W  = $clog2(NUM_CPUS + 1),
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int PEND_W = NUM_CPUS * NUM_IDS,
  localparam int SRC_W  = PEND_W * NUM_CPUS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [CNT_W-1:0]  online_cnt,
  output logic [31:0]       rd_data,
  output logic [PEND_W-1:0] pend_set,
  output logic [SRC_W-1:0]  src_set
);

  swint_req_t          req_f;
  logic [NUM_CPUS-1:0] tgt_mask;
  logic                rsvd;
  logic                fire;

  swint_field_decode u_decode (
    .wr_data (wr_data),
    .req     (req_f)
  );

  swint_target_sel #(.NUM_CPUS(NUM_CPUS)) u_target (
    .req        (req_f),
    .req_cpu    (req_cpu),
    .online_cnt (online_cnt),
    .tgt_mask   (tgt_mask),
    .rsvd       (rsvd)
  );

  assign fire = wr_en & ~rsvd;

  swint_pulse_bank #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .tgt_mask (tgt_mask),
    .id       (req_f.id[ID_W-1:0]),
    .req_cpu  (req_cpu),
    .pend_set (pend_set),
    .src_set  (src_set)
  );

  // Generation register is write-only
  assign rd_data = '0;

endmodule

// File: rtl/swint_fanout_chk.sv
module swint_fanout_chk
  import swint_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IDS  = 16,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W  = $clog2(NUM_CPUS + 1),
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int PEND_W = NUM_CPUS * NUM_IDS,
  localparam int SRC_W  = PEND_W * NUM_CPUS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [31:0]         wr_data,
  input logic [CPU_W-1:0]    req_cpu,
  input logic [CNT_W-1:0]    online_cnt,
  input logic [PEND_W-1:0]   pend_set,
  input logic [SRC_W-1:0]    src_set,
  input logic [NUM_CPUS-1:0] tgt_mask
);

  logic [MODE_W-1:0]   mode_w;
  logic [NUM_CPUS-1:0] live_mask;
  logic [NUM_CPUS-1:0] req_oh;
  logic [NUM_CPUS-1:0] req_oh_q;
  logic [NUM_CPUS-1:0] cpu_hits;
  logic [NUM_IDS-1:0]  id_hits;
  logic [NUM_IDS-1:0]  one_id;
  logic [PEND_W-1:0]   src_any;
  logic [PEND_W-1:0]   foreign;
  logic                unused_chk;

  assign mode_w     = wr_data[MODE_LSB +: MODE_W];
  assign req_oh     = {{(NUM_CPUS-1){1'b0}}, 1'b1} << req_cpu;
  assign one_id     = {{(NUM_IDS-1){1'b0}}, 1'b1};
  assign unused_chk = ^{wr_data[31:MODE_LSB+MODE_W], wr_data[LIST_LSB-1:ID_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) req_oh_q <= '0;
    else        req_oh_q <= req_oh;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    assign live_mask[c] = (online_cnt > CNT_W'(c));
    assign cpu_hits[c]  = |pend_set[c*NUM_IDS +: NUM_IDS];
  end

  for (genvar k = 0; k < PEND_W; k++) begin : g_k
    assign src_any[k] = |src_set[k*NUM_CPUS +: NUM_CPUS];
    assign foreign[k] = |(src_set[k*NUM_CPUS +: NUM_CPUS] & ~req_oh_q);
  end

  always_comb begin
    id_hits = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      id_hits = id_hits | pend_set[c*NUM_IDS +: NUM_IDS];
    end
  end

  assert_id_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((id_hits & ~(one_id << $past(wr_data[ID_W-1:0]))) == '0));

  assert_list_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_w == 2'd0) |=>
      (cpu_hits == ($past(wr_data[LIST_LSB +: NUM_CPUS]) & $past(live_mask))));

  assert_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_w == 2'd1) |=> (cpu_hits == ($past(live_mask) & ~$past(req_oh))));

  assert_self_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_w == 2'd2) |=> (cpu_hits == ($past(live_mask) & $past(req_oh))));

  assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_w == 2'd3) |=> (pend_set == '0 && src_set == '0));

  assert_src_pairs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_any == pend_set);

  assert_src_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (foreign == '0));

  assert_offline_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cpu_hits & ~$past(live_mask)) == '0));

  assert_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cpu_hits == $past(tgt_mask)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (pend_set == '0 && src_set == '0));

endmodule

bind swint_fanout swint_fanout_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_swint_fanout_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .req_cpu    (req_cpu),
  .online_cnt (online_cnt),
  .pend_set   (pend_set),
  .src_set    (src_set),
  .tgt_mask   (tgt_mask)
);

// File: tb/test_swint_fanout.sv
`timescale 1ns/1ps
module test_swint_fanout;

  localparam int NC = 8;
  localparam int NI = 16;
  localparam int PW = NC * NI;
  localparam int SW = PW * NC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [31:0]   wr_data;
  logic [2:0]    req_cpu;
  logic [3:0]    online_cnt;
  logic [31:0]   rd_data;
  logic [PW-1:0] pend_set;
  logic [SW-1:0] src_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PW-1:0] exp_p;
  logic [SW-1:0] exp_s;

  always #5 clk = ~clk;

  swint_fanout i_swint_fanout (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .req_cpu    (req_cpu),
    .online_cnt (online_cnt),
    .rd_data    (rd_data),
    .pend_set   (pend_set),
    .src_set    (src_set)
  );

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Expected pulses computed arithmetically from the requirements
  task automatic build_exp(input int m, input int list, input int rq, input int on, input int id);
    int live;
    int tg;
    live = (on >= NC) ? ((1 << NC) - 1) : ((1 << on) - 1);   // R7
    case (m)
      0: tg = list & live;
      1: tg = live & ~(1 << rq);
      2: tg = (1 << rq) & live;
      default: tg = 0;
    endcase
    exp_p = '0;
    exp_s = '0;
    for (int c = 0; c < NC; c++) begin
      if (((tg >> c) & 1) == 1) begin
        exp_p[c*NI + id] = 1'b1;
        exp_s[(c*NI + id)*NC + rq] = 1'b1;
      end
    end
  endtask

  function automatic logic [31:0] word(input int m, input int list, input int id);
    return {6'b101101, 2'(m), 8'(list), 12'hA5C, 4'(id)};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lists[4];
    int ons[9];
    int idc;
    lists = '{8'hFF, 8'hA5, 8'h00, 8'h5A};
    ons   = '{0, 1, 2, 3, 5, 7, 8, 9, 15};
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; req_cpu = '0; online_cnt = 4'd8;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset, even with a strobe present
    wr_en = 1'b1; wr_data = word(0, 8'hFF, 3);
    @(negedge clk);
    chk("R10 pend in reset", SW'(pend_set), '0);
    chk("R10 src in reset", src_set, '0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pend after reset", SW'(pend_set), '0);
    chk("R9 read zero", SW'(rd_data), '0);

    // Sweep: online count x writer x mode x list, interrupt number rotating
    idc = 0;
    foreach (ons[oi]) begin
      for (int rq = 0; rq < NC; rq++) begin
        for (int m = 0; m < 4; m++) begin
          foreach (lists[li]) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = word(m, lists[li], idc);
            req_cpu = 3'(rq); online_cnt = 4'(ons[oi]);
            build_exp(m, lists[li], rq, ons[oi], idc);
            @(negedge clk);
            wr_en = 1'b0;
            chk({mode_tag(m), " R1 R7 pend"}, SW'(pend_set), SW'(exp_p));
            chk("R6 src", src_set, exp_s);
            chk("R9 read zero", SW'(rd_data), '0);
            @(negedge clk);
            chk("R8 pulse width", SW'(pend_set), '0);
            idc = (idc + 5) % NI;
          end
        end
      end
    end

    // Back-to-back train: each cycle must carry only the previous write
    for (int n = 0; n < 48; n++) begin
      int m;
      int rq;
      int on;
      int ls;
      int id;
      @(negedge clk);
      if (n > 0) begin
        chk("R8 train pend", SW'(pend_set), SW'(exp_p));
        chk("R6 train src", src_set, exp_s);
      end
      m  = n % 4;
      rq = (n * 3) % NC;
      on = 1 + (n % 9);
      ls = (n * 37 + 11) & 8'hFF;
      id = (n * 7) % NI;
      wr_en = 1'b1; wr_data = word(m, ls, id);
      req_cpu = 3'(rq); online_cnt = 4'(on);
      build_exp(m, ls, rq, on, id);
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 train last pend", SW'(pend_set), SW'(exp_p));
    chk("R6 train last src", src_set, exp_s);
    @(negedge clk);
    chk("R8 train drained", SW'(pend_set), '0);
    chk("R8 train drained src", src_set, '0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule